// File: doc/BRIEF.md
# Eight-Pin Bidirectional Port with Switchable Pulldowns

This block is a byte-wide general-purpose I/O port that sits on a small processor's register bus. It holds three registers: an output value latch, a per-pin direction mask and a per-pin pulldown inhibit mask. For each pin it drives an output enable, an output value and a pulldown enable to the pad ring. It samples the pad levels through a synchronizer so that software can read them.

Reading the data address gives a per-pin mix. Pins set as outputs return their latch bit, and pins set as inputs return their synchronized pad level. Pulldowns can only be switched on at input pins. The inhibit mask can turn each one off. A strap input, looked at while reset is held, decides whether reset leaves every pulldown on or every pulldown off.

The bus has no back-pressure. A write strobe that is high at a clock edge is always taken in that one cycle. Read data is a pure function of the address and the current state, so every access finishes in one cycle and there is no valid/ready pair at the edge of the block.

Top module: `bidir_port`

## Requirements
- R1: A direction bit of 1 turns on `pin_oe` for that pin, and 0 turns it off. The direction mask lives at address 0x04, reads back as written, and reset clears it to 0x00 so every pin starts as an input.
- R2: A read at address 0x00 returns, for bit i, the latch bit i when direction bit i is 1, and the synchronized level of pin i when direction bit i is 0.
- R3: A write to address 0x00 always loads the latch, whatever the direction mask holds, and `pin_out` shows the latch. On input pins the new latch value does not change the data read until the pin becomes an output.
- R4: A change on `pin_in` appears in data reads exactly two rising edges later, and not after one.
- R5: `pin_pd_en[i]` is 1 exactly when direction bit i is 0 and inhibit bit i is 0. An output pin never has its pulldown on.
- R6: The inhibit mask lives at address 0x10, with bit i belonging to pin i, and 1 turns the pulldown off. It is write-only: reads at 0x10 return 0x00.
- R7: Reset clears the latch and the direction mask. It loads the inhibit mask with all zeros when `cfg_pd_off` is 0 and all ones when it is 1, using the value seen at the clock edges while reset is held. Changing `cfg_pd_off` after reset has no effect.
- R8: Any address other than 0x00, 0x04 or 0x10 reads as 0x00, and a write to it changes no register.
- R9: A write takes effect at the rising edge where `bus_wr` is high. Pin outputs show the new value from that edge on, and reads return it in the same cycle as the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_pd_off | input | 1 | Reset-time strap: 1 makes reset turn all pulldowns off |
| bus_addr | input | 5 | Register address |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 8 | Pad levels as seen at the pins |
| pin_oe | output | 8 | Per-pin output buffer enable |
| pin_out | output | 8 | Per-pin output value |
| pin_pd_en | output | 8 | Per-pin pulldown enable |

## Verification
A register write lands at the edge that samples the strobe, so the pin enables and values are due one edge after the write. Read data follows the address in the same cycle. A pad change reaches the data read only after the second edge. The bench changes its inputs just after a rising edge and makes every comparison half a cycle later. Its behavioural model steps its registers and a two-entry pin history once per edge, and it is compared with every output on every cycle. Directed checks test the pin-sampling latency once after one edge and again after two, so a synchronizer that is too short or too long is caught.

// File: rtl/bidir_port_pkg.sv
package bidir_port_pkg;
  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_DIR,
    SEL_PDI
  } reg_sel_e;
endpackage

// File: rtl/bport_decode.sv
module bport_decode
  import bidir_port_pkg::*;
#(
  parameter int AW = 5,
  parameter logic [AW-1:0] A_DATA = 'h00,
  parameter logic [AW-1:0] A_DIR  = 'h04,
  parameter logic [AW-1:0] A_PDI  = 'h10
) (
  input  logic [AW-1:0] addr,
  output reg_sel_e      sel
);
  always_comb begin
    if (addr == A_DATA)     sel = SEL_DATA;
    else if (addr == A_DIR) sel = SEL_DIR;
    else if (addr == A_PDI) sel = SEL_PDI;
    else                    sel = SEL_NONE;
  end
endmodule

// File: rtl/bport_regs.sv
module bport_regs
  import bidir_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_pd_off,
  input  logic         wr,
  input  reg_sel_e     sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lat_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] pdi_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '0;
      pdi_q <= {W{cfg_pd_off}};
    end else if (wr) begin
      unique case (sel)
        SEL_DATA: lat_q <= wdata;
        SEL_DIR:  dir_q <= wdata;
        SEL_PDI:  pdi_q <= wdata;
        default:  ;
      endcase
    end
  end

  // R1: a direction write lands at the strobe edge
  p_dir_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_DIR) |=> dir_q == $past(wdata));

  // R3: a data write loads the latch regardless of direction
  p_lat_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_DATA) |=> lat_q == $past(wdata));

  // R8: an unmapped write leaves every register unchanged
  p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_NONE) |=>
      (lat_q == $past(lat_q) && dir_q == $past(dir_q) && pdi_q == $past(pdi_q)));

  // R7: on leaving reset the inhibit mask follows the strap
  p_reset_pdi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (pdi_q == {W{$past(cfg_pd_off)}} && dir_q == '0));
endmodule

// File: rtl/bport_sync.sv
module bport_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int AGE_W = $clog2(STAGES + 1);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= din;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[k] <= '0;
      else        stage_q[k] <= stage_q[k-1];
    end
  end

  assign dout = stage_q[STAGES-1];

  // Cycles since reset, saturating, so the latency check only looks at real samples
  logic [AGE_W-1:0] age_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                         age_q <= '0;
    else if (age_q != AGE_W'(STAGES))   age_q <= age_q + 1'b1;
  end

  if (STAGES == 2) begin : g_chk2
    // R4: a pin level reaches the read path exactly two edges later
    p_sync_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == AGE_W'(STAGES)) |-> dout == $past(din, 2));
  end
endmodule

// File: rtl/bport_pad_ctl.sv
module bport_pad_ctl
  import bidir_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  reg_sel_e     sel,
  input  logic [W-1:0] lat_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] pdi_q,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] pd_en,
  output logic [W-1:0] rdata
);
  logic [W-1:0] data_view;

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pd_en[i]     = ~dir_q[i] & ~pdi_q[i];
    assign data_view[i] = dir_q[i] ? lat_q[i] : pin_sync[i];
  end

  always_comb begin
    unique case (sel)
      SEL_DATA: rdata = data_view;
      SEL_DIR:  rdata = dir_q;
      default:  rdata = '0;
    endcase
  end

  // R6: the inhibit mask never reads back
  p_pdi_rd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_PDI) |-> rdata == '0);

  // R8: unmapped addresses read as zero
  p_rd_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> rdata == '0);
endmodule

// File: rtl/bidir_port.sv
module bidir_port
  import bidir_port_pkg::*;
#(
  parameter int W           = 8,
  parameter int AW          = 5,
  parameter int SYNC_STAGES = 2,
  parameter logic [AW-1:0] A_DATA = 'h00,
  parameter logic [AW-1:0] A_DIR  = 'h04,
  parameter logic [AW-1:0] A_PDI  = 'h10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_pd_off,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_oe,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_pd_en
);
  reg_sel_e     sel;
  logic [W-1:0] lat_q, dir_q, pdi_q, pin_sync;

  bport_decode #(.AW(AW), .A_DATA(A_DATA), .A_DIR(A_DIR), .A_PDI(A_PDI)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  bport_regs #(.W(W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_pd_off (cfg_pd_off),
    .wr         (bus_wr),
    .sel        (sel),
    .wdata      (bus_wdata),
    .lat_q      (lat_q),
    .dir_q      (dir_q),
    .pdi_q      (pdi_q)
  );

  bport_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pin_in),
    .dout  (pin_sync)
  );

  bport_pad_ctl #(.W(W)) u_pad (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .lat_q    (lat_q),
    .dir_q    (dir_q),
    .pdi_q    (pdi_q),
    .pin_sync (pin_sync),
    .pd_en    (pin_pd_en),
    .rdata    (bus_rdata)
  );

  assign pin_oe  = dir_q;
  assign pin_out = lat_q;

  // R5: no pin drives and pulls down at the same time
  p_no_pd_on_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & pin_pd_en) == '0);
endmodule

// File: tb/bidir_port_tb_top.sv
`timescale 1ns/1ps
module bidir_port_tb_top;
  localparam int W  = 8;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_pd_off = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata, pin_oe, pin_out, pin_pd_en, pin_lvl;
  logic [W-1:0]  ext_en = '0, ext_val = '0;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  bit cmp_on = 1'b0;

  always #2 clk = ~clk;

  // Pad model: own driver wins, then an external driver, then the weak pulldown;
  // an undriven pad with its pulldown off settles high.
  assign pin_lvl = (pin_oe & pin_out) | (~pin_oe & ext_en & ext_val) |
                   (~pin_oe & ~ext_en & ~pin_pd_en);

  bidir_port dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_pd_off(cfg_pd_off),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_lvl), .pin_oe(pin_oe),
    .pin_out(pin_out), .pin_pd_en(pin_pd_en)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference
  logic [W-1:0] m_lat = '0, m_dir = '0, m_pdi = '0;
  logic [W-1:0] m_hist [$];

  always @(posedge clk) begin
    logic [W-1:0] pd, pad;
    pd  = ~m_dir & ~m_pdi;
    pad = (m_dir & m_lat) | (~m_dir & ext_en & ext_val) | (~m_dir & ~ext_en & ~pd);
    if (!rst_n) begin
      m_lat = '0;
      m_dir = '0;
      m_pdi = cfg_pd_off ? '1 : '0;
      m_hist = '{'0, '0};
    end else begin
      m_hist.push_back(pad);
      void'(m_hist.pop_front());
      if (bus_wr) begin
        if (bus_addr == 5'h00)      m_lat = bus_wdata;
        else if (bus_addr == 5'h04) m_dir = bus_wdata;
        else if (bus_addr == 5'h10) m_pdi = bus_wdata;
      end
    end
    cmp_on = 1'b1;
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      logic [W-1:0] erd;
      chk("R1 pin_oe", pin_oe, m_dir);
      chk("R3 pin_out", pin_out, m_lat);
      chk("R5 pin_pd_en", pin_pd_en, ~m_dir & ~m_pdi);
      if (bus_addr == 5'h00) begin
        erd = (m_dir & m_lat) | (~m_dir & m_hist[0]);
        chk("R2 data read", bus_rdata, erd);
      end else if (bus_addr == 5'h04) chk("R1 dir read", bus_rdata, m_dir);
      else if (bus_addr == 5'h10)     chk("R6 inhibit read", bus_rdata, '0);
      else                            chk("R8 unmapped read", bus_rdata, '0);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    #2;
    chk("R7 reset oe", pin_oe, 8'h00);
    chk("R7 reset out", pin_out, 8'h00);
    chk("R7 reset pd strap0", pin_pd_en, 8'hFF);

    step(); wr(5'h04, 8'h0F);
    #2 chk("R9 oe after write edge", pin_oe, 8'h0F);

    step(); wr(5'h00, 8'hA5);
    #2 chk("R3 latch on out", pin_out, 8'hA5);
    chk("R2 mixed read", bus_rdata, 8'h05);

    step(); wr(5'h10, 8'hF0);
    #2 chk("R5 pd off", pin_pd_en, 8'h00);
    bus_addr = 5'h10;
    #1 chk("R6 write-only", bus_rdata, 8'h00);
    bus_addr = 5'h00;
    step(); step();
    #2 chk("R2 floating high after inhibit", bus_rdata, 8'hF5);

    step();
    ext_en = 8'hF0; ext_val = 8'h30;
    step();
    #2 chk("R4 one edge", bus_rdata, 8'hF5);
    step();
    #2 chk("R4 two edges", bus_rdata, 8'h35);

    step(); wr(5'h08, 8'hFF);
    #2 chk("R8 oe kept", pin_oe, 8'h0F);
    chk("R8 out kept", pin_out, 8'hA5);
    chk("R8 read zero", bus_rdata, 8'h00);

    step(); wr(5'h00, 8'hF0);
    bus_addr = 5'h00;
    #2 chk("R3 input read unaffected", bus_rdata, 8'h30);
    step(); wr(5'h04, 8'hFF);
    bus_addr = 5'h00;
    #2 chk("R3 latch shows once output", bus_rdata, 8'hF0);

    step();
    rst_n = 1'b0; cfg_pd_off = 1'b1;
    step(); step();
    rst_n = 1'b1; cfg_pd_off = 1'b0;
    #2 chk("R7 strap1 pd", pin_pd_en, 8'h00);
    chk("R7 strap1 oe", pin_oe, 8'h00);
    step();
    #2 chk("R7 strap ignored after reset", pin_pd_en, 8'h00);

    ext_en = '0;
    for (int n = 0; n < 3000; n++) begin
      int r;
      step();
      r = $urandom_range(0, 19);
      if (r == 0) begin
        rst_n = 1'b0; cfg_pd_off = 1'($urandom);
      end else begin
        rst_n = 1'b1;
      end
      ext_en  = W'($urandom);
      ext_val = W'($urandom);
      case ($urandom_range(0, 3))
        0: bus_addr = 5'h00;
        1: bus_addr = 5'h04;
        2: bus_addr = 5'h10;
        default: bus_addr = AW'($urandom);
      endcase
      bus_wdata = W'($urandom);
      bus_wr    = ($urandom_range(0, 2) == 0);
    end
    step();
    bus_wr = 1'b0; rst_n = 1'b1;
    step(); step();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule